// File: doc/BRIEF.md
# Virtual CPU Scheduling Base Register Controller

This block holds the two 64-bit base registers that a per-CPU interrupt router uses to track a virtual CPU: a scheduling register and a property register. The scheduling register carries the table address, the attribute fields, a VALID bit that marks the virtual CPU as resident, and a LastPending status bit. The property register describes the virtual configuration table and is stored as written. Software reaches both registers through 32-bit half-word or full 64-bit accesses.

Writes to the scheduling register follow transition rules keyed on the old and new VALID values. A write that keeps VALID at 1 is dropped and raises a one-cycle change flag if it tried to alter anything. A write that keeps VALID at 0 is stored. A write that sets VALID forces LastPending to 1. A write that clears VALID records in LastPending whether the external priority scanner held a pending enabled interrupt. Each VALID transition pulses a rescan request to that scanner. A targeted invalidate-all command also pulses the rescan request, but only when the virtual CPU is resident. While the virtual CPU is not resident, the block presents the scanner's best priority as 0xFF.

Top module: `vpend_base_ctrl`

## Requirements
- R1: After reset both registers read as zero, `scan_go` and `chg_flag` are 0, and `eff_prio` is 0xFF.
- R2: Only these scheduling-register bits are writable: VALID (bit 63), IDAI (bit 62), LastPending (bit 61), outer cache [58:56], address [51:16], shareability [11:10] and inner cache [9:7]. The DIRTY bit (bit 60) and every other bit always read 0.
- R3: A scheduling write with VALID 0 in both the old and new values stores the writable bits as given, including LastPending, and produces no `scan_go` pulse.
- R4: A scheduling write with VALID 1 in both the old and new values leaves the register unchanged. One cycle later `chg_flag` pulses for one cycle if the writable bits of the new value differ from the stored value, and stays 0 if they are equal.
- R5: A scheduling write that takes VALID from 0 to 1 stores the value with LastPending forced to 1, and `scan_go` is 1 in the following cycle.
- R6: A scheduling write that takes VALID from 1 to 0 stores the value with LastPending equal to `best_vld` at the write edge, and `scan_go` is 1 in the following cycle.
- R7: A 32-bit write (`wr_wide`=0) puts `wr_data[31:0]` in the high half when `wr_hi`=1 and in the low half otherwise. The other half is kept, and the transition rules apply to the merged 64-bit value.
- R8: The property register (`wr_sel`=1) stores every bit of a 64-bit or 32-bit write, never pulses `scan_go` or `chg_flag`, and never changes the scheduling register.
- R9: `eff_prio` equals 0xFF while VALID is 0 and equals `best_prio` while VALID is 1.
- R10: `inv_all` pulses `scan_go` in the following cycle only when VALID is 1 and `inv_addr` equals the stored address field [51:16]. Otherwise it has no effect.
- R11: `rd_data` is combinational. It returns the whole register selected by `rd_sel` when `rd_wide`=1. Otherwise it returns the half chosen by `rd_hi` (1 = high) in bits [31:0], with bits [63:32] zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 scheduling, 1 property |
| wr_wide | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| wr_hi | input | 1 | Half select for 32-bit writes (1 = high) |
| wr_data | input | 64 | Write data (bits [31:0] for 32-bit writes) |
| rd_sel | input | 1 | Read target: 0 scheduling, 1 property |
| rd_wide | input | 1 | 1 = 64-bit read |
| rd_hi | input | 1 | Half select for 32-bit reads |
| rd_data | output | 64 | Read data |
| inv_all | input | 1 | Invalidate-all command strobe |
| inv_addr | input | 36 | Table address carried by the invalidate-all command |
| best_vld | input | 1 | Scanner holds a pending enabled virtual interrupt |
| best_prio | input | 8 | Scanner's best pending priority |
| eff_prio | output | 8 | Best priority as presented to the CPU interface |
| scan_go | output | 1 | One-cycle rescan request to the scanner |
| chg_flag | output | 1 | One-cycle pulse when a resident-state write tried a change |

## Verification
The bench builds the block with its default widths: 64-bit registers split into 32-bit halves, a 36-bit address field and 8-bit priorities. With these widths one half-word write can clear or set VALID while the other half keeps the address. A single invalidate-all address can therefore be compared against the exact field value that the bench placed through both write widths. The tests cover every pairing of old and new VALID, both values of `best_vld` at a deschedule, and matching and mismatching invalidate addresses.

// File: rtl/vpb_pkg.sv
package vpb_pkg;

    localparam int REG_W   = 64;
    localparam int HALF_W  = REG_W / 2;
    localparam int PRIO_W  = 8;

    localparam int B_VALID = 63;
    localparam int B_IDAI  = 62;
    localparam int B_PLAST = 61;
    localparam int B_DIRTY = 60;
    localparam int OC_LO   = 56;
    localparam int OC_HI   = 58;
    localparam int ADDR_LO = 16;
    localparam int ADDR_HI = 51;
    localparam int ADDR_W  = ADDR_HI - ADDR_LO + 1;
    localparam int SH_LO   = 10;
    localparam int SH_HI   = 11;
    localparam int IC_LO   = 7;
    localparam int IC_HI   = 9;

    typedef enum logic {
        SEL_SCHED = 1'b0,
        SEL_PROP  = 1'b1
    } reg_sel_e;

    typedef enum logic [1:0] {
        ACT_STORE   = 2'd0,
        ACT_IGNORE  = 2'd1,
        ACT_SCHED   = 2'd2,
        ACT_DESCHED = 2'd3
    } sched_act_e;

    typedef struct packed {
        logic              wide;
        logic              hi;
        logic [REG_W-1:0]  data;
    } wr_req_t;

    function automatic logic [REG_W-1:0] field_bits(input int lo, input int hi);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [REG_W-1:0] sched_wmask();
        return field_bits(B_VALID, B_VALID) | field_bits(B_IDAI, B_IDAI) |
               field_bits(B_PLAST, B_PLAST) | field_bits(OC_LO, OC_HI) |
               field_bits(ADDR_LO, ADDR_HI) | field_bits(SH_LO, SH_HI) |
               field_bits(IC_LO, IC_HI);
    endfunction

endpackage

// File: rtl/vpb_merge.sv
module vpb_merge
    import vpb_pkg::*;
(
    input  logic [REG_W-1:0] cur,
    input  wr_req_t          req,
    output logic [REG_W-1:0] merged
);
    always_comb begin
        if (req.wide) begin
            merged = req.data;
        end else if (req.hi) begin
            merged = {req.data[HALF_W-1:0], cur[HALF_W-1:0]};
        end else begin
            merged = {cur[REG_W-1:HALF_W], req.data[HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/vpb_sched_rule.sv
module vpb_sched_rule
    import vpb_pkg::*;
(
    input  logic [REG_W-1:0] cur,
    input  logic [REG_W-1:0] cand,
    input  logic             best_vld,
    output sched_act_e       act,
    output logic [REG_W-1:0] nxt,
    output logic             differ
);
    localparam logic [REG_W-1:0] WMASK = sched_wmask();

    logic [REG_W-1:0] kept;
    logic             old_v;
    logic             new_v;

    assign kept  = cand & WMASK;
    assign old_v = cur[B_VALID];
    assign new_v = cand[B_VALID];

    always_comb begin
        nxt    = cur;
        differ = 1'b0;
        act    = ACT_STORE;
        unique case ({old_v, new_v})
            2'b11: begin
                act    = ACT_IGNORE;
                differ = (kept != cur);
            end
            2'b00: begin
                act = ACT_STORE;
                nxt = kept;
            end
            2'b01: begin
                act           = ACT_SCHED;
                nxt           = kept;
                nxt[B_PLAST]  = 1'b1;
            end
            default: begin
                act           = ACT_DESCHED;
                nxt           = kept;
                nxt[B_PLAST]  = best_vld;
            end
        endcase
    end
endmodule

// File: rtl/vpb_read_mux.sv
module vpb_read_mux
    import vpb_pkg::*;
(
    input  logic [REG_W-1:0] sched_q,
    input  logic [REG_W-1:0] prop_q,
    input  logic             sel,
    input  logic             wide,
    input  logic             hi,
    output logic [REG_W-1:0] data
);
    logic [REG_W-1:0] pick;

    assign pick = (reg_sel_e'(sel) == SEL_PROP) ? prop_q : sched_q;

    always_comb begin
        if (wide) begin
            data = pick;
        end else if (hi) begin
            data = {{HALF_W{1'b0}}, pick[REG_W-1:HALF_W]};
        end else begin
            data = {{HALF_W{1'b0}}, pick[HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/vpend_base_ctrl.sv
module vpend_base_ctrl
    import vpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic              wr_wide,
    input  logic              wr_hi,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_sel,
    input  logic              rd_wide,
    input  logic              rd_hi,
    output logic [REG_W-1:0]  rd_data,
    input  logic              inv_all,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic              best_vld,
    input  logic [PRIO_W-1:0] best_prio,
    output logic [PRIO_W-1:0] eff_prio,
    output logic              scan_go,
    output logic              chg_flag
);
    localparam int NREG = 2;

    logic [REG_W-1:0] sched_q;
    logic [REG_W-1:0] prop_q;
    logic [REG_W-1:0] cur_arr    [NREG];
    logic [REG_W-1:0] merged_arr [NREG];
    logic [REG_W-1:0] cand;
    logic [REG_W-1:0] sched_nxt;
    logic             differ;
    sched_act_e       act;
    wr_req_t          req;
    logic             sched_wr;
    logic             prop_wr;
    logic             resident;
    logic             transition;

    assign req      = '{wide: wr_wide, hi: wr_hi, data: wr_data};
    assign sched_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_SCHED);
    assign prop_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_PROP);

    assign cur_arr[0] = sched_q;
    assign cur_arr[1] = prop_q;

    for (genvar g = 0; g < NREG; g++) begin : g_merge
        vpb_merge u_merge (
            .cur    (cur_arr[g]),
            .req    (req),
            .merged (merged_arr[g])
        );
    end

    assign cand = merged_arr[0];

    vpb_sched_rule u_rule (
        .cur      (sched_q),
        .cand     (cand),
        .best_vld (best_vld),
        .act      (act),
        .nxt      (sched_nxt),
        .differ   (differ)
    );

    vpb_read_mux u_rd (
        .sched_q (sched_q),
        .prop_q  (prop_q),
        .sel     (rd_sel),
        .wide    (rd_wide),
        .hi      (rd_hi),
        .data    (rd_data)
    );

    assign resident   = sched_q[B_VALID] && (sched_q[ADDR_HI:ADDR_LO] == inv_addr);
    assign transition = sched_wr && ((act == ACT_SCHED) || (act == ACT_DESCHED));
    assign eff_prio   = sched_q[B_VALID] ? best_prio : {PRIO_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            sched_q  <= '0;
            prop_q   <= '0;
            scan_go  <= 1'b0;
            chg_flag <= 1'b0;
        end else begin
            scan_go  <= transition || (inv_all && resident);
            chg_flag <= sched_wr && (act == ACT_IGNORE) && differ;
            if (sched_wr) sched_q <= sched_nxt;
            if (prop_wr)  prop_q  <= merged_arr[1];
        end
    end
endmodule

// File: rtl/vpb_checker.sv
module vpb_checker
    import vpb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_sel,
    input logic              inv_all,
    input logic [REG_W-1:0]  sched_q,
    input logic [REG_W-1:0]  cand,
    input logic [PRIO_W-1:0] eff_prio,
    input logic              scan_go,
    input logic              chg_flag
);
    // R4
    resident_write_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && sched_q[B_VALID] && cand[B_VALID]) |=> $stable(sched_q));

    // R5
    sched_sets_last_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sched_q[B_VALID]) |-> sched_q[B_PLAST]);

    // R6
    valid_edge_scans_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sched_q[B_VALID]) || $fell(sched_q[B_VALID])) |-> scan_go);

    // R9
    idle_prio_chk: assert property (@(posedge clk) disable iff (rst)
        !sched_q[B_VALID] |-> (eff_prio == {PRIO_W{1'b1}}));

    // R8
    prop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && !inv_all) |=> (!scan_go && !chg_flag && $stable(sched_q)));

    // R4
    flag_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        chg_flag |-> $past(sched_q[B_VALID]));

    // R2
    dirty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=> !sched_q[B_DIRTY]);
endmodule

bind vpend_base_ctrl vpb_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .inv_all  (inv_all),
    .sched_q  (sched_q),
    .cand     (cand),
    .eff_prio (eff_prio),
    .scan_go  (scan_go),
    .chg_flag (chg_flag)
);

// File: tb/vpend_base_ctrl_test.sv
module vpend_base_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_sel = 1'b0, wr_wide = 1'b0, wr_hi = 1'b0;
    logic [63:0] wr_data = '0;
    logic        rd_sel = 1'b0, rd_wide = 1'b1, rd_hi = 1'b0;
    logic [63:0] rd_data;
    logic        inv_all = 1'b0;
    logic [35:0] inv_addr = '0;
    logic        best_vld = 1'b0;
    logic [7:0]  best_prio = 8'h00;
    logic [7:0]  eff_prio;
    logic        scan_go, chg_flag;

    int nvec = 0;
    int nbad = 0;

    localparam logic [63:0] WMASK = 64'hE70F_FFFF_FFFF_0F80;

    always #5 clk = ~clk;

    vpend_base_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_wide(wr_wide),
        .wr_hi(wr_hi), .wr_data(wr_data), .rd_sel(rd_sel), .rd_wide(rd_wide),
        .rd_hi(rd_hi), .rd_data(rd_data), .inv_all(inv_all), .inv_addr(inv_addr),
        .best_vld(best_vld), .best_prio(best_prio), .eff_prio(eff_prio),
        .scan_go(scan_go), .chg_flag(chg_flag)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic sel, input logic wide, input logic hi, output logic [63:0] v);
        rd_sel = sel; rd_wide = wide; rd_hi = hi;
        #1 v = rd_data;
    endtask

    // drives at a falling edge, samples pulses at the next falling edge
    task automatic wr(input logic sel, input logic wide, input logic hi,
                      input logic [63:0] d, output logic sg, output logic cf);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_wide = wide; wr_hi = hi; wr_data = d;
        @(negedge clk);
        sg = scan_go; cf = chg_flag;
        wr_en = 1'b0;
    endtask

    task automatic inv(input logic [35:0] a, output logic sg);
        @(negedge clk);
        inv_all = 1'b1; inv_addr = a;
        @(negedge clk);
        sg = scan_go;
        inv_all = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rd(0, 1, 0, v); chk("R1 sched reset", v, 64'h0);
        rd(1, 1, 0, v); chk("R1 prop reset", v, 64'h0);
        chk("R1 scan_go reset", {63'h0, scan_go}, 64'h0);
        chk("R1 chg_flag reset", {63'h0, chg_flag}, 64'h0);
        chk("R1 eff_prio reset", {56'h0, eff_prio}, 64'hFF);
    endtask

    task automatic t_store_idle();
        logic [63:0] v; logic sg, cf;
        wr(0, 1, 0, 64'h7FFF_FFFF_FFFF_FFFF, sg, cf);
        rd(0, 1, 0, v);
        chk("R2 R3 masked store", v, 64'h7FFF_FFFF_FFFF_FFFF & WMASK);
        chk("R2 dirty reads zero", {63'h0, v[60]}, 64'h0);
        chk("R3 no scan", {63'h0, sg}, 64'h0);
    endtask

    task automatic t_schedule();
        logic [63:0] v; logic sg, cf;
        best_prio = 8'h40;
        wr(0, 1, 0, 64'h8000_1234_5678_0000, sg, cf);
        rd(0, 1, 0, v);
        chk("R5 stored with last forced", v, 64'hA000_1234_5678_0000);
        chk("R5 scan pulse", {63'h0, sg}, 64'h1);
        chk("R9 prio passes", {56'h0, eff_prio}, 64'h40);
    endtask

    task automatic t_ignore();
        logic [63:0] v; logic sg, cf;
        wr(0, 1, 0, 64'h8000_9999_0000_0380, sg, cf);
        rd(0, 1, 0, v);
        chk("R4 unchanged", v, 64'hA000_1234_5678_0000);
        chk("R4 flag on differ", {63'h0, cf}, 64'h1);
        chk("R4 no scan", {63'h0, sg}, 64'h0);
        @(negedge clk);
        chk("R4 flag one cycle", {63'h0, chg_flag}, 64'h0);
        wr(0, 1, 0, 64'hA000_1234_5678_0000, sg, cf);
        chk("R4 no flag on equal", {63'h0, cf}, 64'h0);
    endtask

    task automatic t_inv_resident();
        logic sg;
        inv(36'h0_1234_5678, sg);
        chk("R10 match scans", {63'h0, sg}, 64'h1);
        inv(36'h0_1234_5679, sg);
        chk("R10 mismatch ignored", {63'h0, sg}, 64'h0);
    endtask

    task automatic t_desched_half();
        logic [63:0] v; logic sg, cf;
        best_vld = 1'b1;
        wr(0, 0, 1, 64'h0, sg, cf);
        best_vld = 1'b0;
        rd(0, 1, 0, v);
        chk("R6 R7 last from pending", v, 64'h2000_0000_5678_0000);
        chk("R6 scan pulse", {63'h0, sg}, 64'h1);
        chk("R9 prio forced", {56'h0, eff_prio}, 64'hFF);
        wr(0, 0, 1, 64'h0000_0000_8000_0001, sg, cf);
        rd(0, 1, 0, v);
        chk("R5 R7 half schedule", v, 64'hA000_0001_5678_0000);
        chk("R5 half scan", {63'h0, sg}, 64'h1);
    endtask

    task automatic t_desched_empty();
        logic [63:0] v; logic sg, cf;
        wr(0, 1, 0, 64'h0, sg, cf);
        rd(0, 1, 0, v);
        chk("R6 last clear when empty", v, 64'h0);
        chk("R6 scan pulse", {63'h0, sg}, 64'h1);
        inv(36'h0, sg);
        chk("R10 non-resident ignored", {63'h0, sg}, 64'h0);
    endtask

    task automatic t_prop();
        logic [63:0] v; logic sg, cf;
        wr(1, 1, 0, 64'hDEAD_BEEF_0123_4567, sg, cf);
        rd(1, 1, 0, v);
        chk("R8 wide store", v, 64'hDEAD_BEEF_0123_4567);
        chk("R8 no scan", {62'h0, sg, cf}, 64'h0);
        wr(1, 0, 1, 64'h0000_0000_CAFE_F00D, sg, cf);
        rd(1, 1, 0, v);
        chk("R8 half store", v, 64'hCAFE_F00D_0123_4567);
        rd(0, 1, 0, v);
        chk("R8 sched untouched", v, 64'h0);
        rd(1, 0, 1, v);
        chk("R11 high half read", v, 64'h0000_0000_CAFE_F00D);
        rd(1, 0, 0, v);
        chk("R11 low half read", v, 64'h0000_0000_0123_4567);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_store_idle();
        wr_data = '0;
        begin
            logic sg, cf;
            wr(0, 1, 0, 64'h0, sg, cf);
        end
        t_schedule();
        t_ignore();
        t_inv_resident();
        t_desched_half();
        t_desched_empty();
        t_prop();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #2000000;
        nbad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule